// File: doc/BRIEF.md
# Bus Transfer Error Status Capture

This block sits beside a system bus and turns one-cycle error event pulses into two things: a transfer-error signal that tells the bus master its transfer failed, and a set of sticky status fields that software reads later to learn the cause. Six sources feed it. They are a bus-monitor timeout, an error from an on-chip slave (with the slave's index), a data parity error (with the failing byte lane and the bank accessed), a double-bit ECC error (with its bank), a single-bit ECC error (with its bank) and a write to a read-only region.

Not every event is fatal. A single-bit ECC error is normally corrected and only counted by a saturating counter. Once that counter is full, every further single-bit error is escalated to a transfer error. A write-protect violation is logged but never raises the transfer error by itself. Software clears flags by writing ones to them and resets the counter with a clear pulse. All pins are plain control and status lines. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `xfer_err_capture`

## Requirements
- R1: After reset, `tea_o`, all six flags, `sbe_count`, `err_bank`, `err_lane` and `err_slave` are zero.
- R2: A bus-monitor, internal-slave, parity or double-ECC event makes `tea_o` high for exactly the cycle after the event's clock edge. It also sets its flag: bit 0 bus monitor, bit 1 internal slave, bit 2 parity, bit 3 double ECC.
- R3: An internal-slave event loads `ev_int_slave` into `err_slave`.
- R4: A parity event loads `ev_par_lane` into `err_lane` and `ev_par_bank` into `err_bank`.
- R5: A double-ECC event loads `ev_dbl_bank` into `err_bank`.
- R6: A single-ECC event while `sbe_count` is below its maximum raises no `tea_o` and sets no flag. It increments `sbe_count` by one.
- R7: `sbe_count` saturates at all ones and never wraps.
- R8: A single-ECC event while `sbe_count` is already at its maximum raises `tea_o`, sets flag bit 4 and loads `ev_sgl_bank` into `err_bank`.
- R9: A write-protect event sets flag bit 5 and by itself raises no `tea_o`.
- R10: Flags are sticky. A 1 in `sw_flag_clr` clears that flag on the next edge. If a set and a clear hit the same bit in the same cycle, the set wins.
- R11: A pulse on `sw_cnt_clr` zeroes `sbe_count` on the next edge and takes priority over an increment in that cycle.
- R12: Events in the same cycle set all their flags together. `err_bank` takes its value from the highest-priority recording event, in the order double ECC, then parity, then escalated single ECC. `err_lane` changes only on a parity event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_bm_tmo | input | 1 | Bus-monitor timeout pulse |
| ev_int_err | input | 1 | On-chip slave error pulse |
| ev_int_slave | input | SLV_W | Index of the failing on-chip slave |
| ev_par_err | input | 1 | Data parity error pulse |
| ev_par_lane | input | LANE_W | Byte lane with the parity error |
| ev_par_bank | input | BANK_W | Bank accessed during the parity error |
| ev_dbl_ecc | input | 1 | Double-bit ECC error pulse |
| ev_dbl_bank | input | BANK_W | Bank of the double-bit error |
| ev_sgl_ecc | input | 1 | Single-bit ECC error pulse |
| ev_sgl_bank | input | BANK_W | Bank of the single-bit error |
| ev_wr_prot | input | 1 | Write-to-read-only pulse |
| sw_flag_clr | input | 6 | Write-one-to-clear mask for the flags |
| sw_cnt_clr | input | 1 | Clear pulse for the single-bit counter |
| tea_o | output | 1 | Transfer-error assert |
| err_flags | output | 6 | Sticky cause flags |
| err_bank | output | BANK_W | Recorded bank |
| err_lane | output | LANE_W | Recorded parity byte lane |
| err_slave | output | SLV_W | Recorded on-chip slave |
| sbe_count | output | CNT_W | Single-bit error counter |

## Verification
The bench builds the block with a 4-bit counter (`CNT_W = 4`) instead of the default 8 bits. With this width, saturation takes fifteen single-bit events rather than 255, so the bench can cover both the counter sitting at its maximum and the escalation that follows in a short run. The bank, lane and slave widths keep their defaults (3, 3 and 2 bits). These widths leave room for distinct values on the three bank inputs, so the priority between recording events can be seen at `err_bank`.

// File: rtl/xerr_pkg.sv
package xerr_pkg;
  localparam int FLAG_N   = 6;
  localparam int FLG_BM   = 0;
  localparam int FLG_INT  = 1;
  localparam int FLG_PAR  = 2;
  localparam int FLG_DBL  = 3;
  localparam int FLG_SGL  = 4;
  localparam int FLG_WP   = 5;
endpackage

// File: rtl/xerr_sbe_cnt.sv
module xerr_sbe_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             sat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign sat = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (inc && !sat) cnt <= cnt + 1'b1;
  end

  // R7: once full and not cleared, the count holds at its maximum
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sat && !clr) |=> sat);
  // R11: a clear pulse empties the counter on the next edge
  a_r11_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/xerr_decide.sv
module xerr_decide
  import xerr_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              bm,
  input  logic              ie,
  input  logic              par,
  input  logic              dbl,
  input  logic              sgl,
  input  logic              wp,
  input  logic              sbe_sat,
  input  logic [BANK_W-1:0] par_bank,
  input  logic [BANK_W-1:0] dbl_bank,
  input  logic [BANK_W-1:0] sgl_bank,
  output logic [FLAG_N-1:0] set_vec,
  output logic              tea_d,
  output logic              bank_ld,
  output logic [BANK_W-1:0] bank_val
);
  logic sgl_esc;

  assign sgl_esc = sgl & sbe_sat;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_BM]  = bm;
    set_vec[FLG_INT] = ie;
    set_vec[FLG_PAR] = par;
    set_vec[FLG_DBL] = dbl;
    set_vec[FLG_SGL] = sgl_esc;
    set_vec[FLG_WP]  = wp;
  end

  assign tea_d = bm | ie | par | dbl | sgl_esc;

  always_comb begin
    bank_ld  = 1'b1;
    bank_val = '0;
    if (dbl)          bank_val = dbl_bank;
    else if (par)     bank_val = par_bank;
    else if (sgl_esc) bank_val = sgl_bank;
    else              bank_ld  = 1'b0;
  end
endmodule

// File: rtl/xerr_status.sv
module xerr_status
  import xerr_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int LANE_W = 3,
  parameter int SLV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set_vec,
  input  logic [FLAG_N-1:0] clr_vec,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_val,
  input  logic              lane_ld,
  input  logic [LANE_W-1:0] lane_val,
  input  logic              slv_ld,
  input  logic [SLV_W-1:0]  slv_val,
  output logic [FLAG_N-1:0] flags,
  output logic [BANK_W-1:0] bank_q,
  output logic [LANE_W-1:0] lane_q,
  output logic [SLV_W-1:0]  slv_q
);
  genvar g;
  generate
    for (g = 0; g < FLAG_N; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)          flags[g] <= 1'b0;
        else if (set_vec[g]) flags[g] <= 1'b1;
        else if (clr_vec[g]) flags[g] <= 1'b0;
      end
      // R10: a raised flag stays raised unless software clears it
      a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[g] && !clr_vec[g]) |=> flags[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      lane_q <= '0;
      slv_q  <= '0;
    end else begin
      if (bank_ld) bank_q <= bank_val;
      if (lane_ld) lane_q <= lane_val;
      if (slv_ld)  slv_q  <= slv_val;
    end
  end

  // R12: lane record only moves on a parity event
  a_r12_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_ld |=> $stable(lane_q));
endmodule

// File: rtl/xfer_err_capture.sv
module xfer_err_capture
  import xerr_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int LANE_W = 3,
  parameter int SLV_W  = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_bm_tmo,
  input  logic              ev_int_err,
  input  logic [SLV_W-1:0]  ev_int_slave,
  input  logic              ev_par_err,
  input  logic [LANE_W-1:0] ev_par_lane,
  input  logic [BANK_W-1:0] ev_par_bank,
  input  logic              ev_dbl_ecc,
  input  logic [BANK_W-1:0] ev_dbl_bank,
  input  logic              ev_sgl_ecc,
  input  logic [BANK_W-1:0] ev_sgl_bank,
  input  logic              ev_wr_prot,
  input  logic [5:0]        sw_flag_clr,
  input  logic              sw_cnt_clr,
  output logic              tea_o,
  output logic [5:0]        err_flags,
  output logic [BANK_W-1:0] err_bank,
  output logic [LANE_W-1:0] err_lane,
  output logic [SLV_W-1:0]  err_slave,
  output logic [CNT_W-1:0]  sbe_count
);
  logic              sbe_sat;
  logic [FLAG_N-1:0] set_vec;
  logic              tea_d;
  logic              bank_ld;
  logic [BANK_W-1:0] bank_val;

  xerr_sbe_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_sgl_ecc), .clr(sw_cnt_clr),
    .cnt(sbe_count), .sat(sbe_sat)
  );

  xerr_decide #(.BANK_W(BANK_W)) u_decide (
    .bm(ev_bm_tmo), .ie(ev_int_err), .par(ev_par_err), .dbl(ev_dbl_ecc),
    .sgl(ev_sgl_ecc), .wp(ev_wr_prot), .sbe_sat(sbe_sat),
    .par_bank(ev_par_bank), .dbl_bank(ev_dbl_bank), .sgl_bank(ev_sgl_bank),
    .set_vec(set_vec), .tea_d(tea_d), .bank_ld(bank_ld), .bank_val(bank_val)
  );

  xerr_status #(.BANK_W(BANK_W), .LANE_W(LANE_W), .SLV_W(SLV_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(sw_flag_clr),
    .bank_ld(bank_ld), .bank_val(bank_val),
    .lane_ld(ev_par_err), .lane_val(ev_par_lane),
    .slv_ld(ev_int_err), .slv_val(ev_int_slave),
    .flags(err_flags), .bank_q(err_bank), .lane_q(err_lane), .slv_q(err_slave)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tea_o <= 1'b0;
    else        tea_o <= tea_d;
  end

  // R2: a double-bit error always raises the transfer error next cycle
  a_r2_dbl_tea: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dbl_ecc |=> (tea_o && err_flags[FLG_DBL]));
  // R9: a lone write-protect event is logged without transfer error
  a_r9_wp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_prot && !ev_bm_tmo && !ev_int_err && !ev_par_err && !ev_dbl_ecc && !ev_sgl_ecc)
    |=> (!tea_o && err_flags[FLG_WP]));
  // R6: an absorbed single-bit error on its own stays silent
  a_r6_sbe_absorbed: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sgl_ecc && !sbe_sat && !ev_bm_tmo && !ev_int_err && !ev_par_err && !ev_dbl_ecc)
    |=> !tea_o);
  // R8: single-bit error at a full counter escalates
  a_r8_sbe_escalate: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sgl_ecc && sbe_sat) |=> (tea_o && err_flags[FLG_SGL]));
endmodule

// File: tb/xfer_err_capture_bench.sv
module xfer_err_capture_bench;
  localparam int BANK_W = 3;
  localparam int LANE_W = 3;
  localparam int SLV_W  = 2;
  localparam int CNT_W  = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_bm_tmo = 0, ev_int_err = 0, ev_par_err = 0, ev_dbl_ecc = 0;
  logic ev_sgl_ecc = 0, ev_wr_prot = 0, sw_cnt_clr = 0;
  logic [SLV_W-1:0]  ev_int_slave = '0;
  logic [LANE_W-1:0] ev_par_lane = '0;
  logic [BANK_W-1:0] ev_par_bank = '0, ev_dbl_bank = '0, ev_sgl_bank = '0;
  logic [5:0]        sw_flag_clr = '0;
  logic              tea_o;
  logic [5:0]        err_flags;
  logic [BANK_W-1:0] err_bank;
  logic [LANE_W-1:0] err_lane;
  logic [SLV_W-1:0]  err_slave;
  logic [CNT_W-1:0]  sbe_count;

  always #10ns clk = ~clk;

  xfer_err_capture #(.BANK_W(BANK_W), .LANE_W(LANE_W), .SLV_W(SLV_W), .CNT_W(CNT_W))
  u_xfer_err_capture (
    .clk(clk), .rst_n(rst_n), .ev_bm_tmo(ev_bm_tmo), .ev_int_err(ev_int_err),
    .ev_int_slave(ev_int_slave), .ev_par_err(ev_par_err), .ev_par_lane(ev_par_lane),
    .ev_par_bank(ev_par_bank), .ev_dbl_ecc(ev_dbl_ecc), .ev_dbl_bank(ev_dbl_bank),
    .ev_sgl_ecc(ev_sgl_ecc), .ev_sgl_bank(ev_sgl_bank), .ev_wr_prot(ev_wr_prot),
    .sw_flag_clr(sw_flag_clr), .sw_cnt_clr(sw_cnt_clr), .tea_o(tea_o),
    .err_flags(err_flags), .err_bank(err_bank), .err_lane(err_lane),
    .err_slave(err_slave), .sbe_count(sbe_count)
  );

  typedef struct {
    int    tea, flags, cnt, bank, lane, slv;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference state, built from the requirements
  int m_flags = 0, m_cnt = 0, m_bank = 0, m_lane = 0, m_slv = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, predicted outcome queued for the monitor
  task automatic drive(string tag, bit bm = 0, bit ie = 0, int slv = 0,
                       bit par = 0, int lane = 0, int pb = 0,
                       bit dbl = 0, int db = 0, bit sgl = 0, int sb = 0,
                       bit wp = 0, int clr = 0, bit cclr = 0);
    exp_t e;
    bit esc;
    @(negedge clk);
    ev_bm_tmo = bm; ev_int_err = ie; ev_int_slave = SLV_W'(slv);
    ev_par_err = par; ev_par_lane = LANE_W'(lane); ev_par_bank = BANK_W'(pb);
    ev_dbl_ecc = dbl; ev_dbl_bank = BANK_W'(db);
    ev_sgl_ecc = sgl; ev_sgl_bank = BANK_W'(sb);
    ev_wr_prot = wp; sw_flag_clr = 6'(clr); sw_cnt_clr = cclr;
    esc = sgl && (m_cnt == CMAX);
    m_flags = (m_flags & ~clr) | (int'(bm) | int'(ie) << 1 | int'(par) << 2 |
              int'(dbl) << 3 | int'(esc) << 4 | int'(wp) << 5);
    if (cclr) m_cnt = 0; else if (sgl && m_cnt < CMAX) m_cnt++;
    if (dbl) m_bank = db; else if (par) m_bank = pb; else if (esc) m_bank = sb;
    if (par) m_lane = lane;
    if (ie)  m_slv = slv;
    e.tea = int'(bm | ie | par | dbl | esc);
    e.flags = m_flags; e.cnt = m_cnt; e.bank = m_bank; e.lane = m_lane;
    e.slv = m_slv; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares after each edge, mid-high phase
  initial begin
    forever begin
      @(posedge clk);
      #5ns;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "tea_o", int'(tea_o), e.tea);
        chk(e.tag, "err_flags", int'(err_flags), e.flags);
        chk(e.tag, "sbe_count", int'(sbe_count), e.cnt);
        chk(e.tag, "err_bank", int'(err_bank), e.bank);
        chk(e.tag, "err_lane", int'(err_lane), e.lane);
        chk(e.tag, "err_slave", int'(err_slave), e.slv);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tea_o", int'(tea_o), 0);
    chk("R1", "err_flags", int'(err_flags), 0);
    chk("R1", "sbe_count", int'(sbe_count), 0);
    chk("R1", "records", int'(err_bank) + int'(err_lane) + int'(err_slave), 0);
    rst_n = 1'b1;
    drive("R2", .bm(1));
    drive("R2");                               // pulse drops after one cycle
    drive("R3", .ie(1), .slv(2));
    drive("R3");
    drive("R4", .par(1), .lane(5), .pb(3));
    drive("R5", .dbl(1), .db(6));
    drive("R5");
    drive("R10", .clr(6'h3F));                 // clear all flags
    drive("R10", .bm(1), .clr(6'h01));         // set wins over clear
    drive("R10");                              // sticky with no clear
    drive("R9", .wp(1), .clr(6'h01));
    drive("R9");
    for (int i = 0; i < CMAX; i++) drive("R6", .sgl(1), .sb(i % 8));
    drive("R7", .sgl(1), .sb(4));              // escalates, count holds
    drive("R8");
    drive("R12", .par(1), .lane(3), .pb(2), .sgl(1), .sb(7));
    drive("R12", .bm(1), .ie(1), .slv(1), .dbl(1), .db(1), .par(1), .lane(6),
          .pb(5), .sgl(1), .sb(4), .wp(1));
    drive("R11", .sgl(1), .sb(3), .cclr(1));   // clear beats increment
    drive("R11", .sgl(1), .sb(2), .clr(6'h3F));
    drive("R12", .dbl(1), .db(2), .sgl(1), .sb(6), .par(1), .lane(1), .pb(7));
    drive("R6", .sgl(1), .sb(5));
    drive("R1");
    drive("R1");
    @(negedge clk);
    finish_run();
  end
endmodule